// File: doc/BRIEF.md
# Integer Compare Execution Unit

This unit carries out the integer compare instructions of a 16-bit microcontroller core. The core hands it one instruction word together with the two code words that follow it in the program. The unit decodes the instruction and reads its register operands one at a time through a single read port into a register file of sixteen 16-bit entries. It then compares a first operand with a second operand and updates three condition flags. These flags are equality (Z), signed greater (N) and unsigned greater (L). The unit also reports how many code words the instruction used, so that fetch can advance the program counter.

Operands come in three sizes. Byte compares look only at the low 8 bits of a register. Word compares use all 16 bits. Double compares join two neighbouring registers into a 32-bit value. In every size the first operand is the immediate, or the first register field, and it is the value tested as the larger one. A short 4-bit immediate code covers small constants. One code value works as an escape that takes the whole next code word as the immediate. A separate double form carries a full 32-bit immediate in the next two code words. The unit never writes a register. It ends every instruction with a one-cycle done pulse. If the opcode is not one it knows, it raises an illegal flag and leaves the condition flags as they were.

Top module: `cmp_exec_unit`

## Requirements
- R1: The upper byte of insnWord selects the compare: 0x50 is byte against immediate, 0x51 is byte against byte, 0x52 is word against immediate, 0x53 is word against word, 0x56 is double against short immediate and 0x57 is double against double. When bits 15:4 equal 0x009, the instruction is a double compare against a 32-bit immediate, and bits 3:0 name the register pair. wordsUsed reports 1, 2 or 3 code words.
- R2: flagZ is 1 exactly when the two operands are equal.
- R3: flagN is 1 exactly when the first operand is greater than the second, with both read as two's complement.
- R4: flagL is 1 exactly when the first operand is greater than the second, with both read as unsigned.
- R5: Bits 7:4 hold the immediate code or the first register index. Bits 3:0 hold the second register index. A byte compare uses only bits 7:0 of each operand, so differences in bits 15:8 have no effect.
- R6: A word compare uses bits 15:0. An immediate code other than 11 is a 4-bit two's complement value, sign-extended to the operand width (code 0xF is -1).
- R7: Immediate code 11 is an escape. The immediate is then extWord0, and wordsUsed is 2. Otherwise wordsUsed is 1 for these forms.
- R8: A double register operand with index k takes register k+1 (modulo 16) as bits 31:16 and register k as bits 15:0. A difference in only the upper register gives flagZ=0. Overlapping pairs are allowed.
- R9: A 16-bit immediate, whether short or escaped, is sign-extended to 32 bits in a double compare.
- R10: In the 32-bit-immediate form, extWord0 supplies bits 15:0 and extWord1 supplies bits 31:16, and wordsUsed is 3.
- R11: Any other opcode gives done with illegalOp=1 and leaves all three flags unchanged.
- R12: done is a single-cycle pulse. The flags change only in the cycle where done is high. start is accepted only while the unit is idle and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin executing insnWord |
| insnWord | input | 16 | Instruction word |
| extWord0 | input | 16 | First code word after the instruction |
| extWord1 | input | 16 | Second code word after the instruction |
| regAddr | output | 4 | Register file read index |
| regData | input | 16 | Register file read data for regAddr, same cycle |
| done | output | 1 | One-cycle completion pulse |
| illegalOp | output | 1 | Opcode not recognised; valid with done |
| flagZ | output | 1 | Equal flag |
| flagN | output | 1 | Signed-greater flag |
| flagL | output | 1 | Unsigned-greater flag |
| wordsUsed | output | 2 | Code words consumed; valid with done |

## Verification
Each compare form is run with equal operands, with a first operand that is larger both signed and unsigned, and with a negative first operand that is larger only unsigned. Because N and L disagree in that last case, it separates the signed test from the unsigned one. Byte and double tests put differences in only the bits that should be ignored, or only in the upper register. This shows whether the operand width and the pair assembly are right. Escaped immediates with bit 15 set, word-order-sensitive 32-bit immediates, overlapping and wrapping register pairs, and unknown opcodes after a known flag state cover the remaining corners.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int DATA_W = 16;
  localparam int REG_AW = 4;
  localparam int CODE_W = 4;
  localparam int WIDE_W = 2 * DATA_W;
  localparam logic [CODE_W-1:0] ESC_CODE = 4'd11;

  localparam logic [7:0] OP_BYTE_IMM = 8'h50;
  localparam logic [7:0] OP_BYTE_REG = 8'h51;
  localparam logic [7:0] OP_WORD_IMM = 8'h52;
  localparam logic [7:0] OP_WORD_REG = 8'h53;
  localparam logic [7:0] OP_DBL_IMM  = 8'h56;
  localparam logic [7:0] OP_DBL_REG  = 8'h57;
  localparam logic [11:0] OP_DBL_I32 = 12'h009;

  // read mask bits: 0 first-low, 1 first-high, 2 second-low, 3 second-high
  localparam int NREAD = 4;

  typedef enum logic [1:0] {W_BYTE, W_WORD, W_DBL} widthE;

  typedef struct packed {
    logic             legal;
    widthE            width;
    logic             aImm;
    logic             imm32;
    logic [NREAD-1:0] readMask;
    logic [1:0]       words;
  } decodeT;

  typedef struct packed {
    logic       loadIn;
    logic       capEn;
    logic [1:0] capSel;
    logic       cmpEn;
    widthE      width;
    logic       aImm;
    logic       imm32;
  } strobeT;

  function automatic decodeT decodeInsn(input logic [DATA_W-1:0] w);
    decodeT d;
    logic [1:0] shortWords;
    shortWords = (w[7:4] == ESC_CODE) ? 2'd2 : 2'd1;
    d = '{legal: 1'b1, width: W_BYTE, aImm: 1'b0, imm32: 1'b0,
          readMask: 4'b0101, words: 2'd1};
    if (w[15:4] == OP_DBL_I32) begin
      d.width = W_DBL; d.aImm = 1'b1; d.imm32 = 1'b1;
      d.readMask = 4'b1100; d.words = 2'd3;
    end else begin
      case (w[15:8])
        OP_BYTE_IMM: begin d.aImm = 1'b1; d.readMask = 4'b0100; d.words = shortWords; end
        OP_BYTE_REG: ;
        OP_WORD_IMM: begin d.width = W_WORD; d.aImm = 1'b1; d.readMask = 4'b0100; d.words = shortWords; end
        OP_WORD_REG: d.width = W_WORD;
        OP_DBL_IMM:  begin d.width = W_DBL; d.aImm = 1'b1; d.readMask = 4'b1100; d.words = shortWords; end
        OP_DBL_REG:  begin d.width = W_DBL; d.readMask = 4'b1111; end
        default:     d.legal = 1'b0;
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/cmp_ctrl.sv
module cmp_ctrl
  import cmp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [DATA_W-1:0]   insnWord,
  output strobeT              strobe,
  output logic                done,
  output logic                illegalOp,
  output logic [1:0]          wordsUsed
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_CMP} stateE;

  stateE            state;
  decodeT           held;
  decodeT           decNow;
  logic [NREAD-1:0] pend;
  logic [NREAD-1:0] pendNext;
  logic [1:0]       pickIdx;
  logic             accept;

  assign decNow = decodeInsn(insnWord);
  assign accept = start && (state == S_IDLE) && !done;

  always_comb begin
    pickIdx = 2'd0;
    for (int i = NREAD - 1; i >= 0; i--) begin
      if (pend[i]) pickIdx = 2'(i);
    end
    pendNext = pend & ~(NREAD'(1) << pickIdx);
  end

  always_comb begin
    strobe.loadIn = accept;
    strobe.capEn  = (state == S_READ);
    strobe.capSel = pickIdx;
    strobe.cmpEn  = (state == S_CMP);
    strobe.width  = held.width;
    strobe.aImm   = held.aImm;
    strobe.imm32  = held.imm32;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      held      <= '0;
      pend      <= '0;
      done      <= 1'b0;
      illegalOp <= 1'b0;
      wordsUsed <= 2'd0;
    end else begin
      done      <= 1'b0;
      illegalOp <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (decNow.legal) begin
            held  <= decNow;
            pend  <= decNow.readMask;
            state <= S_READ;
          end else begin
            done      <= 1'b1;
            illegalOp <= 1'b1;
            wordsUsed <= 2'd1;
          end
        end
        S_READ: begin
          pend <= pendNext;
          if (pendNext == '0) state <= S_CMP;
        end
        S_CMP: begin
          done      <= 1'b1;
          wordsUsed <= held.words;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R12: a new instruction is never taken while one is in flight
  p_no_restart_r12: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |=> !$past(strobe.loadIn));

  // R1: every read cycle fetches a register the decoded form asked for
  p_read_listed_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capEn |-> pend[pickIdx]);
endmodule

// File: rtl/cmp_datapath.sv
module cmp_datapath
  import cmp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strobe,
  input  logic [DATA_W-1:0]   insnWord,
  input  logic [DATA_W-1:0]   ext0In,
  input  logic [DATA_W-1:0]   ext1In,
  output logic [REG_AW-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regData,
  output logic                flagZ,
  output logic                flagN,
  output logic                flagL
);
  logic [DATA_W-1:0] insnR, ext0R, ext1R;
  logic [DATA_W-1:0] opRegs [NREAD];
  logic [REG_AW-1:0] firstIdx, secondIdx, firstHi, secondHi;
  logic [CODE_W-1:0] immCode;
  logic [DATA_W-1:0] imm16;
  logic [7:0]        aByte;
  logic [DATA_W-1:0] aWord;
  logic [WIDE_W-1:0] opA, opB;

  assign firstIdx  = insnR[7:4];
  assign secondIdx = insnR[3:0];
  assign firstHi   = firstIdx + REG_AW'(1);
  assign secondHi  = secondIdx + REG_AW'(1);
  assign immCode   = insnR[7:4];

  always_comb begin
    case (strobe.capSel)
      2'd0:    regAddr = firstIdx;
      2'd1:    regAddr = firstHi;
      2'd2:    regAddr = secondIdx;
      default: regAddr = secondHi;
    endcase
  end

  always_comb begin
    imm16 = (immCode == ESC_CODE) ? ext0R
                                  : {{(DATA_W-CODE_W){immCode[CODE_W-1]}}, immCode};
    aByte = strobe.aImm ? imm16[7:0] : opRegs[0][7:0];
    aWord = strobe.aImm ? imm16 : opRegs[0];
    case (strobe.width)
      W_BYTE: begin
        opA = {{(WIDE_W-8){aByte[7]}}, aByte};
        opB = {{(WIDE_W-8){opRegs[2][7]}}, opRegs[2][7:0]};
      end
      W_WORD: begin
        opA = {{DATA_W{aWord[DATA_W-1]}}, aWord};
        opB = {{DATA_W{opRegs[2][DATA_W-1]}}, opRegs[2]};
      end
      default: begin
        if (strobe.imm32)     opA = {ext1R, ext0R};
        else if (strobe.aImm) opA = {{DATA_W{imm16[DATA_W-1]}}, imm16};
        else                  opA = {opRegs[1], opRegs[0]};
        opB = {opRegs[3], opRegs[2]};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      insnR <= '0;
      ext0R <= '0;
      ext1R <= '0;
    end else if (strobe.loadIn) begin
      insnR <= insnWord;
      ext0R <= ext0In;
      ext1R <= ext1In;
    end
  end

  for (genvar g = 0; g < NREAD; g++) begin : g_opreg
    always_ff @(posedge clk) begin
      if (!rstN)                                       opRegs[g] <= '0;
      else if (strobe.capEn && strobe.capSel == 2'(g)) opRegs[g] <= regData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagZ <= 1'b0;
      flagN <= 1'b0;
      flagL <= 1'b0;
    end else if (strobe.cmpEn) begin
      flagZ <= (opA == opB);
      flagN <= ($signed(opA) > $signed(opB));
      flagL <= (opA > opB);
    end
  end

  // R2: equality excludes either greater-than result
  p_eq_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    flagZ |-> (!flagN && !flagL));

  // R8: the high half of a second pair is read from the register after the low one
  p_pair_order_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capEn && strobe.capSel == 2'd3) |-> (regAddr == secondIdx + REG_AW'(1)));
endmodule

// File: rtl/cmp_exec_unit.sv
module cmp_exec_unit
  import cmp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [DATA_W-1:0]   insnWord,
  input  logic [DATA_W-1:0]   extWord0,
  input  logic [DATA_W-1:0]   extWord1,
  output logic [REG_AW-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regData,
  output logic                done,
  output logic                illegalOp,
  output logic                flagZ,
  output logic                flagN,
  output logic                flagL,
  output logic [1:0]          wordsUsed
);
  strobeT strobe;

  cmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .insnWord(insnWord),
    .strobe(strobe), .done(done), .illegalOp(illegalOp), .wordsUsed(wordsUsed)
  );

  cmp_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .insnWord(insnWord),
    .ext0In(extWord0), .ext1In(extWord1), .regAddr(regAddr), .regData(regData),
    .flagZ(flagZ), .flagN(flagN), .flagL(flagL)
  );

  // R12: done lasts one cycle
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12: flags move only together with done
  p_flags_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable({flagZ, flagN, flagL}));

  // R11: an unknown opcode keeps the previous flags
  p_illegal_keep_r11: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (done && $stable({flagZ, flagN, flagL})));

  // R1: a completed compare reports one to three code words
  p_words_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    (done && !illegalOp) |-> (wordsUsed != 2'd0));
endmodule

// File: tb/cmp_exec_unit_bench.sv
module cmp_exec_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] insnWord = '0, extWord0 = '0, extWord1 = '0;
  logic [3:0]  regAddr;
  logic [15:0] regData;
  logic        done, illegalOp, flagZ, flagN, flagL;
  logic [1:0]  wordsUsed;

  logic [15:0] rf [16];
  int compared = 0;
  int mismatched = 0;
  logic [2:0] gotFlags;
  logic       gotIllegal;
  logic [1:0] gotWords;

  always #2 clk = ~clk;
  assign regData = rf[regAddr];

  cmp_exec_unit u_cmp_exec_unit (
    .clk(clk), .rstN(rstN), .start(start), .insnWord(insnWord),
    .extWord0(extWord0), .extWord1(extWord1), .regAddr(regAddr), .regData(regData),
    .done(done), .illegalOp(illegalOp), .flagZ(flagZ), .flagN(flagN), .flagL(flagL),
    .wordsUsed(wordsUsed)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] expect3(input logic [31:0] a, input logic [31:0] b);
    return {a == b, $signed(a) > $signed(b), a > b};
  endfunction

  task automatic resetRegs();
    for (int i = 0; i < 16; i++) rf[i] = 16'h1111 * 16'(i);
    rf[0] = 16'h0B00; rf[1] = 16'h0A01; rf[2] = 16'h0902;
    rf[3] = 16'h0803; rf[4] = 16'h0704; rf[5] = 16'h0605;
  endtask

  task automatic runOp(input logic [15:0] w, input logic [15:0] e0, input logic [15:0] e1);
    int waitCnt;
    @(negedge clk);
    insnWord = w; extWord0 = e0; extWord1 = e1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitCnt = 0;
    while (!done && waitCnt < 30) begin
      @(negedge clk);
      waitCnt++;
    end
    if (!done) check("R12 done timeout", 0, 1);
    gotFlags = {flagZ, flagN, flagL};
    gotIllegal = illegalOp;
    gotWords = wordsUsed;
    @(negedge clk);
    check("R12 done single cycle", {31'd0, done}, 0);
    check("R12 flags held after done", {29'd0, flagZ, flagN, flagL}, {29'd0, gotFlags});
  endtask

  task automatic testReset();
    check("reset done", {31'd0, done}, 0);
    check("reset flags", {29'd0, flagZ, flagN, flagL}, 0);
    check("reset illegal", {31'd0, illegalOp}, 0);
  endtask

  task automatic testByte();
    resetRegs();
    runOp(16'h5011, 0, 0);   // imm 1 vs r1 low byte 0x01
    check("R2 byte imm equal", gotFlags, expect3(32'd1, 32'd1));
    check("R1 byte imm words", gotWords, 1);
    runOp(16'h5021, 0, 0);   // imm 2 vs 1
    check("R3 R4 byte imm greater", gotFlags, 3'b011);
    runOp(16'h50E1, 0, 0);   // imm -2 vs 1: unsigned only
    check("R6 byte short imm negative", gotFlags, expect3(32'hFFFF_FFFE, 32'd1));
    rf[6] = 16'h12FF;
    runOp(16'h5016, 0, 0);   // imm 1 vs byte -1
    check("R3 byte register negative", gotFlags, 3'b010);
    rf[2] = 16'h2201;
    runOp(16'h5121, 0, 0);   // r2 low 0x01 vs r1 low 0x01, high bytes differ
    check("R5 byte ignores high bits", gotFlags, 3'b100);
  endtask

  task automatic testWord();
    resetRegs();
    runOp(16'h52B1, 16'h0A02, 0);
    check("R7 escape imm greater", gotFlags, expect3(32'h0A02, 32'h0A01));
    check("R7 escape words", gotWords, 2);
    runOp(16'h52B1, 16'hFFFE, 0);
    check("R7 escape imm sign", gotFlags, expect3(32'hFFFF_FFFE, 32'h0A01));
    runOp(16'h52F1, 16'h0A01, 0);  // code 0xF = -1, ext ignored
    check("R6 word short imm -1", gotFlags, 3'b001);
    check("R7 non-escape words", gotWords, 1);
    runOp(16'h5321, 0, 0);
    check("R4 word reg smaller", gotFlags, expect3(32'h0902, 32'h0A01));
    rf[7] = 16'h8000;
    runOp(16'h5371, 0, 0);
    check("R6 word reg sign extend", gotFlags, expect3(32'hFFFF_8000, 32'h0A01));
  endtask

  task automatic testDouble();
    resetRegs();
    runOp(16'h56F0, 0, 0);
    check("R9 double short -1", gotFlags, expect3(32'hFFFF_FFFF, 32'h0A01_0B00));
    rf[8] = 16'h8000; rf[9] = 16'hFFFF;
    runOp(16'h56B8, 16'h8000, 0);
    check("R9 double escape sign extend", gotFlags, 3'b100);
    check("R9 double escape words", gotWords, 2);
    rf[2] = 16'h0B00; rf[3] = 16'h0A02;
    runOp(16'h5720, 0, 0);
    check("R8 high half mismatch", gotFlags, expect3(32'h0A02_0B00, 32'h0A01_0B00));
    rf[2] = 16'h0902;
    runOp(16'h5701, 0, 0);   // (r1,r0) vs (r2,r1) overlap
    check("R8 overlapping pairs", gotFlags, expect3(32'h0A01_0B00, 32'h0902_0A01));
    rf[15] = 16'h0B00; rf[1] = 16'h0B00;
    runOp(16'h57F0, 0, 0);   // (r0,r15) vs (r1,r0)
    check("R8 pair index wraps", gotFlags, 3'b100);
  endtask

  task automatic testImm32();
    resetRegs();
    runOp(16'h0090, 16'h0B00, 16'h0A01);
    check("R10 imm32 equal", gotFlags, 3'b100);
    check("R10 imm32 words", gotWords, 3);
    runOp(16'h0090, 16'h0000, 16'h1000);
    check("R10 imm32 greater", gotFlags, expect3(32'h1000_0000, 32'h0A01_0B00));
    check("R1 imm32 legal", {31'd0, gotIllegal}, 0);
  endtask

  task automatic testIllegal();
    resetRegs();
    runOp(16'h5021, 0, 0);   // leaves 011
    runOp(16'h5400, 0, 0);
    check("R11 illegal flag", {31'd0, gotIllegal}, 1);
    check("R11 flags kept", gotFlags, 3'b011);
    runOp(16'h00A0, 0, 0);
    check("R11 wrong prefix illegal", {31'd0, gotIllegal}, 1);
    runOp(16'h5311, 0, 0);
    check("R1 legal after illegal", {31'd0, gotIllegal}, 0);
    check("R2 same register equal", gotFlags, 3'b100);
  endtask

  bit finished = 0;
  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    resetRegs();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testByte();
    testWord();
    testDouble();
    testImm32();
    testIllegal();
    finishRun();
  end

  initial begin
    #(4 * 100000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end
endmodule